// File: doc/BRIEF.md
# Dual-Clock Block FIFO with Random-Access Slots

This block moves fixed-size packets between two unrelated clock domains. The unit of transfer is an 18-byte slot, not a word. The producer fills its current slot by writing bytes at any offset from 0 to 17, in any order, and then pulses a commit input for one write-clock cycle to hand the slot over. The consumer reads any byte of the oldest committed slot by offset, and pulses a free input for one read-clock cycle to give the slot back.

Inside, each side keeps a slot pointer as a binary register and a Gray register that are updated together. Each Gray pointer crosses to the other domain through a chain of flip-flops and is converted back to binary only at the end of that chain. The byte address is pointer times 18 plus the offset, built from two shifts and an add. A dual-clock byte RAM holds the slots. One slot always stays unused, so full and empty can be told apart.

A byte write at an offset of 18 or more is dropped, so it cannot reach a neighbouring slot. Each flag is raised by its own side's pointer update. It is lowered only once the other side's pointer has crossed over.

Top module: `blkpkt_fifo`

## Requirements
- R1: After the asynchronous reset `arst_n` is released, `rd_empty_o` is 1 and `wr_full_o` is 0.
- R2: A byte written at offset o (0 to 17) of the current write slot comes back on `rd_data_o` when offset o of that slot is presented on `rd_ofs_i`. The data appears one read clock after the offset is presented, and offsets may be written and read in any order.
- R3: Slots reach the reader in commit order. Each pointer steps by exactly one slot per accepted pulse and wraps from the last slot to slot 0.
- R4: A commit pulse while `wr_full_o` is 1 is ignored: the write pointer holds and no extra slot reaches the reader.
- R5: A free pulse while `rd_empty_o` is 1 is ignored: the read pointer holds, and the next committed slot is read back intact.
- R6: With no frees, exactly NUM_BLK-1 slots (31 by default) can be committed before `wr_full_o` rises.
- R7: `wr_full_o` rises on the same write-clock edge that accepts the commit filling the last free slot.
- R8: `rd_empty_o` rises on the same read-clock edge that accepts the free of the last committed slot.
- R9: Each pointer crosses domains in Gray code, and its Gray value changes in at most one bit per clock, including at wraparound.
- R10: `wr_full_o` clears a few write clocks after a free. `rd_empty_o` clears a few read clocks after a commit. Both changes happen through logic clocked in the domain that uses the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Byte write strobe into the current write slot |
| wr_ofs_i | input | 5 | Byte offset inside the current write slot |
| wr_data_i | input | 8 | Byte to write |
| wr_commit_i | input | 1 | One-cycle pulse that hands the current slot to the reader |
| wr_full_o | output | 1 | No free slot is left for commit |
| rd_ofs_i | input | 5 | Byte offset inside the oldest committed slot |
| rd_data_o | output | 8 | Registered read byte, valid one read clock after the offset |
| rd_free_i | input | 1 | One-cycle pulse that releases the oldest slot |
| rd_empty_o | output | 1 | No committed slot is waiting |

## Verification
The bound checker watches these properties on every clock edge:
- a pulse against a set flag leaves the pointer unchanged;
- each pointer only ever steps by one;
- each Gray pointer changes in at most one bit;
- each flag rises only on an accepted pulse in its own domain.

Other behaviours can only be shown by the bench's scenarios, which compare against a scoreboard:
- byte placement by offset, checked by writing offsets in a scrambled order;
- slot order across several pointer wraps;
- the exact capacity of 31 slots;
- the delayed clearing of each flag after the far side's pointer crosses over.

// File: rtl/blkfifo_pkg.sv
package blkfifo_pkg;

   localparam int PW_MAX = 16;

   typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} side_e;

   function automatic logic [PW_MAX-1:0] g2b(input logic [PW_MAX-1:0] g);
      logic [PW_MAX-1:0] b;
      b[PW_MAX-1] = g[PW_MAX-1];
      for (int i = PW_MAX - 2; i >= 0; i--) begin
         b[i] = g[i] ^ b[i+1];
      end
      return b;
   endfunction

endpackage

// File: rtl/bfifo_sync.sv
module bfifo_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bfifo_ptr.sv
module bfifo_ptr
   import blkfifo_pkg::*;
#(
   parameter int    PTR_W = 5,
   parameter side_e SIDE  = SIDE_WR
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             step_i,
   input  logic [PTR_W-1:0] far_gray_i,
   output logic [PTR_W-1:0] bin_o,
   output logic [PTR_W-1:0] gray_o,
   output logic             flag_o
);
   localparam logic FLAG_RST = (SIDE == SIDE_RD);

   logic [PTR_W-1:0] bin_q, gray_q, bin_nx, far_bin;
   logic             flag_q, flag_nx, adv;

   assign far_bin = PTR_W'(g2b(PW_MAX'(far_gray_i)));
   assign adv     = step_i & ~flag_q;
   assign bin_nx  = bin_q + PTR_W'(adv);

   generate
      if (SIDE == SIDE_WR) begin : g_full
         assign flag_nx = (PTR_W'(bin_nx + PTR_W'(1)) == far_bin);
      end else begin : g_empty
         assign flag_nx = (bin_nx == far_bin);
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
         flag_q <= FLAG_RST;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
         flag_q <= flag_nx;
      end
   end

   assign bin_o  = bin_q;
   assign gray_o = gray_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/bfifo_addr.sv
module bfifo_addr #(
   parameter int PTR_W     = 5,
   parameter int OFS_W     = 5,
   parameter int ADDR_W    = 10,
   parameter int BLK_BYTES = 18
) (
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] p, base;

   assign p = ADDR_W'(ptr_i);

   generate
      if (BLK_BYTES == 18) begin : g_shift_add
         assign base = (p << 4) + (p << 1);
      end else begin : g_const_mul
         assign base = ADDR_W'(p * ADDR_W'(BLK_BYTES));
      end
   endgenerate

   assign addr_o = base + ADDR_W'(ofs_i);
endmodule

// File: rtl/bfifo_ram.sv
module bfifo_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 576
) (
   input  logic              wclk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rclk,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge rclk) begin
      rdata_o <= mem[raddr_i];
   end
endmodule

// File: rtl/blkpkt_fifo.sv
module blkpkt_fifo
   import blkfifo_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BLK_BYTES   = 18,
   parameter int NUM_BLK     = 32,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = $clog2(NUM_BLK),
   localparam int OFS_W      = $clog2(BLK_BYTES),
   localparam int DEPTH      = NUM_BLK * BLK_BYTES,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              arst_n,
   input  logic              wr_en_i,
   input  logic [OFS_W-1:0]  wr_ofs_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_commit_i,
   output logic              wr_full_o,
   input  logic [OFS_W-1:0]  rd_ofs_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              rd_free_i,
   output logic              rd_empty_o
);
   generate
      if ((NUM_BLK < 2) || ((NUM_BLK & (NUM_BLK - 1)) != 0)) begin : g_bad_num
         $error("NUM_BLK must be a power of two of at least 2");
      end
      if (BLK_BYTES < 2) begin : g_bad_blk
         $error("BLK_BYTES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PTR_W > PW_MAX) begin : g_bad_ptr
         $error("pointer wider than the package conversion limit");
      end
   endgenerate

   logic [PTR_W-1:0]  wr_bin, wr_gray, rd_bin, rd_gray;
   logic [PTR_W-1:0]  rd_gray_w, wr_gray_r;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              ram_we;

   bfifo_ptr #(.PTR_W(PTR_W), .SIDE(SIDE_WR)) u_wptr (
      .clk(wclk), .arst_n(arst_n), .step_i(wr_commit_i),
      .far_gray_i(rd_gray_w), .bin_o(wr_bin), .gray_o(wr_gray), .flag_o(wr_full_o)
   );

   bfifo_ptr #(.PTR_W(PTR_W), .SIDE(SIDE_RD)) u_rptr (
      .clk(rclk), .arst_n(arst_n), .step_i(rd_free_i),
      .far_gray_i(wr_gray_r), .bin_o(rd_bin), .gray_o(rd_gray), .flag_o(rd_empty_o)
   );

   bfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .arst_n(arst_n), .d_i(rd_gray), .q_o(rd_gray_w)
   );

   bfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .arst_n(arst_n), .d_i(wr_gray), .q_o(wr_gray_r)
   );

   bfifo_addr #(.PTR_W(PTR_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_wa (
      .ptr_i(wr_bin), .ofs_i(wr_ofs_i), .addr_o(waddr)
   );

   bfifo_addr #(.PTR_W(PTR_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_ra (
      .ptr_i(rd_bin), .ofs_i(rd_ofs_i), .addr_o(raddr)
   );

   assign ram_we = wr_en_i && (wr_ofs_i < OFS_W'(BLK_BYTES));

   bfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ram (
      .wclk(wclk), .we_i(ram_we), .waddr_i(waddr), .wdata_i(wr_data_i),
      .rclk(rclk), .raddr_i(raddr), .rdata_o(rd_data_o)
   );
endmodule

// File: rtl/blkpkt_fifo_chk.sv
module blkpkt_fifo_chk #(
   parameter int PTR_W = 5
) (
   input logic             wclk,
   input logic             rclk,
   input logic             arst_n,
   input logic             wr_commit_i,
   input logic             wr_full_o,
   input logic             rd_free_i,
   input logic             rd_empty_o,
   input logic [PTR_W-1:0] wr_bin,
   input logic [PTR_W-1:0] wr_gray,
   input logic [PTR_W-1:0] rd_bin,
   input logic [PTR_W-1:0] rd_gray
);
   p_commit_blocked_r4: assert property (@(posedge wclk) disable iff (!arst_n)
      (wr_full_o && wr_commit_i) |=> (wr_bin == $past(wr_bin)));

   p_free_blocked_r5: assert property (@(posedge rclk) disable iff (!arst_n)
      (rd_empty_o && rd_free_i) |=> (rd_bin == $past(rd_bin)));

   p_wr_step_r3: assert property (@(posedge wclk) disable iff (!arst_n)
      (wr_bin != $past(wr_bin)) |-> (wr_bin == PTR_W'($past(wr_bin) + PTR_W'(1))));

   p_rd_step_r3: assert property (@(posedge rclk) disable iff (!arst_n)
      (rd_bin != $past(rd_bin)) |-> (rd_bin == PTR_W'($past(rd_bin) + PTR_W'(1))));

   p_wr_gray_r9: assert property (@(posedge wclk) disable iff (!arst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);

   p_rd_gray_r9: assert property (@(posedge rclk) disable iff (!arst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

   p_full_rise_r7: assert property (@(posedge wclk) disable iff (!arst_n)
      $rose(wr_full_o) |-> $past(wr_commit_i));

   p_empty_rise_r8: assert property (@(posedge rclk) disable iff (!arst_n)
      $rose(rd_empty_o) |-> $past(rd_free_i));
endmodule

bind blkpkt_fifo blkpkt_fifo_chk #(.PTR_W(PTR_W)) u_chk (
   .wclk(wclk), .rclk(rclk), .arst_n(arst_n),
   .wr_commit_i(wr_commit_i), .wr_full_o(wr_full_o),
   .rd_free_i(rd_free_i), .rd_empty_o(rd_empty_o),
   .wr_bin(wr_bin), .wr_gray(wr_gray), .rd_bin(rd_bin), .rd_gray(rd_gray)
);

// File: tb/blkpkt_fifo_test.sv
`timescale 1ns/1ps
module blkpkt_fifo_test;
   localparam int NB = 32, BB = 18, DW = 8, OW = 5;

   logic wclk = 1'b0, rclk = 1'b0, arst_n = 1'b0;
   logic wr_en = 1'b0, wr_commit = 1'b0, rd_free = 1'b0;
   logic [OW-1:0] wr_ofs = '0, rd_ofs = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic wr_full, rd_empty;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   blkpkt_fifo uut (
      .wclk(wclk), .rclk(rclk), .arst_n(arst_n),
      .wr_en_i(wr_en), .wr_ofs_i(wr_ofs), .wr_data_i(wr_data),
      .wr_commit_i(wr_commit), .wr_full_o(wr_full),
      .rd_ofs_i(rd_ofs), .rd_data_o(rd_data),
      .rd_free_i(rd_free), .rd_empty_o(rd_empty)
   );

   int n_chk = 0, n_bad = 0, rd_blocks = 0, stray_req = 0;
   bit rd_go = 1'b0, mon_busy = 1'b0, drain_chk = 1'b0;
   logic [BB*DW-1:0] exp_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int seed, input int o);
      return DW'((seed * 37 + o * 11 + 5) ^ (seed >> 2));
   endfunction

   // driver: fills a slot in scrambled offset order, commits, records it
   task automatic fill_block(input int seed, input bit expect_accept);
      logic [BB*DW-1:0] blk;
      blk = '0;
      for (int i = 0; i < BB; i++) begin
         int o;
         o = (i * 7) % BB;
         @(negedge wclk);
         wr_en   = 1'b1;
         wr_ofs  = OW'(o);
         wr_data = pat(seed, o);
         blk[o*DW +: DW] = pat(seed, o);
      end
      @(negedge wclk);
      wr_en     = 1'b0;
      wr_commit = 1'b1;
      @(negedge wclk);
      wr_commit = 1'b0;
      if (expect_accept) exp_q.push_back(blk);
   endtask

   // monitor: reads the oldest slot in reverse offset order and compares
   task automatic read_block();
      logic [BB*DW-1:0] blk;
      mon_busy = 1'b1;
      if (exp_q.size() == 0) begin
         check(1'b0, "R3", "slot delivered with none committed", 1, 0);
         blk = '0;
      end else begin
         blk = exp_q.pop_front();
      end
      for (int i = 0; i < BB; i++) begin
         int o;
         o = BB - 1 - i;
         rd_ofs = OW'(o);
         @(posedge rclk);
         #1;
         check(rd_data === blk[o*DW +: DW], "R2", "byte at offset",
               int'(rd_data), int'(blk[o*DW +: DW]));
         @(negedge rclk);
      end
      rd_free = 1'b1;
      @(posedge rclk);
      #1;
      if (drain_chk)
         check(rd_empty == (exp_q.size() == 0), "R8", "empty after free",
               int'(rd_empty), int'(exp_q.size() == 0));
      @(negedge rclk);
      rd_free = 1'b0;
      rd_blocks++;
      mon_busy = 1'b0;
   endtask

   initial begin
      forever begin
         @(negedge rclk);
         if (rd_go && !rd_empty) begin
            read_block();
         end else if (stray_req > 0) begin
            rd_free = 1'b1;
            @(posedge rclk);
            #1;
            check(rd_empty == 1'b1, "R5", "empty after free while empty", int'(rd_empty), 1);
            @(negedge rclk);
            rd_free = 1'b0;
            stray_req--;
         end
      end
   end

   task automatic wait_drained();
      while (exp_q.size() != 0 || mon_busy) @(negedge rclk);
      repeat (2) @(negedge rclk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge wclk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #20 arst_n = 1'b1;
      repeat (3) @(negedge wclk);
      check(rd_empty == 1'b1, "R1", "empty after reset", int'(rd_empty), 1);
      check(wr_full == 1'b0, "R1", "full after reset", int'(wr_full), 0);

      // fill to capacity with the reader held off
      for (int b = 0; b < NB - 1; b++) begin
         fill_block(b, 1'b1);
         if (b == NB - 3) check(wr_full == 1'b0, "R6", "full one slot early", int'(wr_full), 0);
         if (b == NB - 2) check(wr_full == 1'b1, "R7", "full on last commit edge", int'(wr_full), 1);
      end
      repeat (10) @(negedge rclk);
      check(rd_empty == 1'b0, "R10", "empty cleared after commits", int'(rd_empty), 0);

      // commits against a full FIFO
      fill_block(900, 1'b0);
      check(wr_full == 1'b1, "R4", "full after ignored commit", int'(wr_full), 1);
      fill_block(901, 1'b0);
      check(wr_full == 1'b1, "R4", "full after second ignored commit", int'(wr_full), 1);

      // drain and count
      drain_chk = 1'b1;
      rd_go = 1'b1;
      wait_drained();
      rd_go = 1'b0;
      drain_chk = 1'b0;
      check(rd_blocks == NB - 1, "R6", "slots held at capacity", rd_blocks, NB - 1);
      check(rd_blocks == NB - 1, "R4", "no extra slot from ignored commit", rd_blocks, NB - 1);
      repeat (8) @(negedge wclk);
      check(wr_full == 1'b0, "R10", "full cleared after frees", int'(wr_full), 0);

      // frees against an empty FIFO
      check(rd_empty == 1'b1, "R5", "empty before stray frees", int'(rd_empty), 1);
      stray_req = 2;
      while (stray_req != 0) @(negedge wclk);
      fill_block(500, 1'b1);
      rd_go = 1'b1;
      wait_drained();
      check(rd_blocks == NB, "R5", "slot count after stray frees", rd_blocks, NB);

      // concurrent streaming across several pointer wraps
      for (int b = 0; b < 70; b++) begin
         while (wr_full) @(negedge wclk);
         fill_block(1000 + b, 1'b1);
      end
      wait_drained();
      check(rd_blocks == NB + 70, "R3", "streamed slot count", rd_blocks, NB + 70);
      check(rd_empty == 1'b1, "R9", "empty after wrapped stream", int'(rd_empty), 1);
      repeat (8) @(negedge wclk);
      check(wr_full == 1'b0, "R9", "full after wrapped stream", int'(wr_full), 0);

      finish_run();
   end
endmodule